// File: doc/BRIEF.md
# Double-Buffered Frame Base Register

This block keeps the frame buffer start addresses for the two halves of a display panel, an upper half and a lower half. Each half has two registers. Software writes a staging register. The display fetch engine reads a current register. Software may rewrite the staging registers at any moment, even while a frame is being drawn, and the frame in flight is not disturbed. When the controller is running, a vertical sync event moves both staging values into the current registers in a single step.

Every such move sets a sticky "base swapped" flag. An interrupt can be taken from this flag when it is unmasked. Software uses it for double buffering: after each swap it writes the address of the next frame. While the controller is switched off, the current registers follow the staging registers, so the addresses loaded before enabling are already in effect. The lower half's registers only take part when the panel runs in dual-panel mode.

Addresses are doubleword aligned. The three lowest address bits are dropped on every write. Register access uses a simple write strobe and a combinational read port, both indexed by a word offset.

Top module: `frame_base_dbuf`

## Requirements
- R1: After reset, both current addresses, both staging registers, the swap flag, the interrupt mask and `irq` are all zero.
- R2: Any write to a staging register clears the lowest ALIGN_BITS bits (3 by default). A read of that register shows the stored value with these bits at zero, and so does the current address that is later loaded from it.
- R3: While `ctrl_en` is 1, a staging write does not change either current address. Only a vsync event changes them.
- R4: While `ctrl_en` is 1, a cycle with `vsync` high copies the staging values into the current registers. The new values appear on `cur_upper` and `cur_lower` in the following cycle.
- R5: If a staging write and a vsync fall in the same cycle, the current register takes the value the staging register held before that write. The newly written value is moved across at the next vsync.
- R6: The swap flag (bit 0 at offset 2) is set by every vsync that is taken while enabled. It stays set until software writes 1 to bit 0 at offset 2. Writing 0 there has no effect. When a set and a clear fall in the same cycle, the set wins.
- R7: `irq` is high exactly while both the swap flag and the interrupt mask bit (bit 0 at offset 3) are 1.
- R8: While `ctrl_en` is 0, each current register takes its staging value one cycle after the staging value changes. A vsync in this state leaves the swap flag unchanged.
- R9: The lower current register changes only while `dual_panel` is 1. While `dual_panel` is 0, `cur_lower` holds its value through vsyncs and writes.
- R10: The read map is: offset 0 gives upper staging, offset 1 gives lower staging, offset 2 gives the swap flag in bit 0, offset 3 gives the mask in bit 0. Every other bit and offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Display controller enable |
| dual_panel | input | 1 | 1 when the panel is driven as two halves |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Word offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | REG_AW | Word offset of the read |
| rd_data | output | DATA_W | Read data (combinational) |
| vsync | input | 1 | Vertical sync event, one cycle high |
| cur_upper | output | ADDR_W | Current upper-half frame base |
| cur_lower | output | ADDR_W | Current lower-half frame base |
| irq | output | 1 | Swap interrupt |

## Verification
A wrong current register appears on `cur_upper` or `cur_lower` in the cycle after the vsync or write that produced it. For this reason, every vsync and every write in the bench is followed by a comparison against an arithmetic model of both staging and both current values. A stuck or misordered swap flag reaches `irq` and the offset-2 read in the same cycle. This lets the set, clear and set-over-clear orderings be checked one cycle after each operation. Faults in the alignment mask or the read decode appear at once on `rd_data` during the sweep over patterns and offsets.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
   // word offsets of the register port
   localparam int OFS_UPPER = 0;
   localparam int OFS_LOWER = 1;
   localparam int OFS_STAT  = 2;
   localparam int OFS_MASK  = 3;
   localparam int NUM_OFS   = 4;

   // bit carrying the swap flag and the mask inside their words
   localparam int FLAG_BIT  = 0;

   typedef enum logic [1:0] {
      SH_HOLD  = 2'd0,
      SH_TRACK = 2'd1,
      SH_SWAP  = 2'd2
   } shadow_act_e;
endpackage

// File: rtl/fbb_vsync_cond.sv
module fbb_vsync_cond #(
   parameter bit EDGE_MODE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vs_i,
   output logic evt_o
);
   generate
      if (EDGE_MODE) begin : g_edge
         logic vs_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vs_q <= 1'b0;
            else        vs_q <= vs_i;
         end
         assign evt_o = vs_i & ~vs_q;
      end else begin : g_pulse
         assign evt_o = vs_i;
      end
   endgenerate
endmodule

// File: rtl/fbb_regfile.sv
module fbb_regfile
   import fbb_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 3,
   parameter int REG_AW     = 3,
   parameter int NUM_PANELS = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [REG_AW-1:0]                 wr_addr,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic [REG_AW-1:0]                 rd_addr,
   input  logic                              flag_i,
   output logic [NUM_PANELS-1:0][ADDR_W-1:0] stage_o,
   output logic                              mask_o,
   output logic                              clr_o,
   output logic [DATA_W-1:0]                 rd_data
);
   localparam logic [ADDR_W-1:0] KEEP_MASK = {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
   localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STAT);
   localparam logic [REG_AW-1:0] A_MASK = REG_AW'(OFS_MASK);

   logic [NUM_PANELS-1:0][ADDR_W-1:0] stage_q;
   logic                              mask_q;

   genvar p;
   generate
      for (p = 0; p < NUM_PANELS; p++) begin : g_stage
         localparam logic [REG_AW-1:0] A_ME = REG_AW'(OFS_UPPER + p);
         logic hit;
         assign hit = wr_en && (wr_addr == A_ME);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   stage_q[p] <= '0;
            else if (hit) stage_q[p] <= wr_data[ADDR_W-1:0] & KEEP_MASK;
         end
         // R2: nothing with low bits set ever lands in staging
         a_r2_stage_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (stage_q[p][ALIGN_BITS-1:0] == '0));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mask_q <= 1'b0;
      else if (wr_en && (wr_addr == A_MASK))    mask_q <= wr_data[FLAG_BIT];
   end

   assign clr_o   = wr_en && (wr_addr == A_STAT) && wr_data[FLAG_BIT];
   assign stage_o = stage_q;
   assign mask_o  = mask_q;

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_PANELS; i++) begin
         if (rd_addr == REG_AW'(OFS_UPPER + i)) rd_data[ADDR_W-1:0] = stage_q[i];
      end
      if (rd_addr == A_STAT) rd_data[FLAG_BIT] = flag_i;
      if (rd_addr == A_MASK) rd_data[FLAG_BIT] = mask_q;
   end
endmodule

// File: rtl/fbb_shadow.sv
module fbb_shadow
   import fbb_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              take_i,
   input  logic              active_i,
   input  logic [ADDR_W-1:0] stage_i,
   output logic [ADDR_W-1:0] cur_o
);
   shadow_act_e act;
   logic [ADDR_W-1:0] cur_q;

   always_comb begin
      if (!active_i)   act = SH_HOLD;
      else if (!en_i)  act = SH_TRACK;
      else if (take_i) act = SH_SWAP;
      else             act = SH_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= '0;
      else begin
         case (act)
            SH_TRACK, SH_SWAP: cur_q <= stage_i;
            default:           cur_q <= cur_q;
         endcase
      end
   end

   assign cur_o = cur_q;

   // R3: running without a vsync keeps the current base
   a_r3_hold_between_vsync: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !take_i) |=> $stable(cur_o));
   // R4: a taken vsync loads the pre-edge staging value
   a_r4_swap_loads_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && take_i && active_i) |=> (cur_o == $past(stage_i)));
   // R8: disabled controller tracks staging
   a_r8_track_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && active_i) |=> (cur_o == $past(stage_i)));
   // R9: an inactive panel never moves
   a_r9_inactive_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> $stable(cur_o));
endmodule

// File: rtl/fbb_status.sv
module fbb_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic mask_i,
   output logic flag_o,
   output logic irq_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & mask_i;

   // R6: set always lands, even against a clear
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   // R6: flag is sticky without a clear
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
   // R6: flag rises only from a set
   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/frame_base_dbuf.sv
module frame_base_dbuf
   import fbb_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 3,
   parameter int REG_AW     = 3,
   parameter int NUM_PANELS = 2,
   parameter bit VSYNC_EDGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_en,
   input  logic              dual_panel,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              vsync,
   output logic [ADDR_W-1:0] cur_upper,
   output logic [ADDR_W-1:0] cur_lower,
   output logic              irq
);
   generate
      if (NUM_PANELS < 1 || NUM_PANELS > 2) begin : g_bad_panels
         $error("NUM_PANELS must be 1 or 2");
      end
      if (ADDR_W > DATA_W) begin : g_bad_width
         $error("ADDR_W must not exceed DATA_W");
      end
      if (ALIGN_BITS < 1 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
         $error("ALIGN_BITS out of range");
      end
      if ((1 << REG_AW) < NUM_OFS) begin : g_bad_aw
         $error("REG_AW too narrow for the register map");
      end
   endgenerate

   logic [NUM_PANELS-1:0][ADDR_W-1:0] stage;
   logic [NUM_PANELS-1:0][ADDR_W-1:0] cur;
   logic vs_evt, take, mask, clr, flag;

   fbb_vsync_cond #(.EDGE_MODE(VSYNC_EDGE)) u_vs (
      .clk(clk), .rst_n(rst_n), .vs_i(vsync), .evt_o(vs_evt));

   assign take = vs_evt & ctrl_en;

   fbb_regfile #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS),
      .REG_AW(REG_AW), .NUM_PANELS(NUM_PANELS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .flag_i(flag),
      .stage_o(stage), .mask_o(mask), .clr_o(clr), .rd_data(rd_data));

   genvar p;
   generate
      for (p = 0; p < NUM_PANELS; p++) begin : g_panel
         logic active;
         if (p == 0) begin : g_up
            assign active = 1'b1;
         end else begin : g_lo
            assign active = dual_panel;
         end
         fbb_shadow #(.ADDR_W(ADDR_W)) u_sh (
            .clk(clk), .rst_n(rst_n), .en_i(ctrl_en), .take_i(take),
            .active_i(active), .stage_i(stage[p]), .cur_o(cur[p]));
      end
      if (NUM_PANELS == 2) begin : g_two
         assign cur_lower = cur[1];
      end else begin : g_one
         assign cur_lower = '0;
      end
   endgenerate

   assign cur_upper = cur[0];

   fbb_status u_stat (
      .clk(clk), .rst_n(rst_n), .set_i(take), .clr_i(clr),
      .mask_i(mask), .flag_o(flag), .irq_o(irq));

   // R2: the current base is always aligned
   a_r2_cur_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      cur_upper[ALIGN_BITS-1:0] == '0);
   // R7: interrupt needs the flag
   a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (rd_addr != REG_AW'(OFS_STAT)) || rd_data[FLAG_BIT]);
   // R8: vsync while disabled leaves a clear flag clear
   a_r8_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && !irq && !mask && !clr && !flag) |=> !irq);
endmodule

// File: tb/sim_frame_base_dbuf.sv
module sim_frame_base_dbuf;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_en = 1'b0, dual_panel = 1'b0, wr_en = 1'b0, vsync = 1'b0;
   logic [2:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, rd_data, cur_upper, cur_lower;
   logic        irq;
   int total = 0, bad = 0;
   logic [31:0] m_stage_u, m_stage_l, m_cur_u, m_cur_l;

   always #5 clk = ~clk;

   frame_base_dbuf u0 (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .dual_panel(dual_panel),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .vsync(vsync), .cur_upper(cur_upper),
      .cur_lower(cur_lower), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // starts and ends at a falling edge
   task automatic op(input logic w, input logic [2:0] a, input logic [31:0] d, input logic vs);
      wr_en = w; wr_addr = a; wr_data = d; vsync = vs;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; vsync = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cur_upper", cur_upper, 0);
      chk("R1 cur_lower", cur_lower, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 4; a++) begin rd(3'(a), v); chk("R1 reg read", v, 0); end
      ctrl_en = 1'b1; dual_panel = 1'b1;
      m_cur_u = 0; m_cur_l = 0;

      // sweep patterns: R2 masking, R3 no change, R4 swap
      for (int i = 0; i < 16; i++) begin
         m_stage_u = (32'h1357_9BDF * (i + 1)) ^ (32'h1 << i);
         m_stage_l = ~m_stage_u + 32'(i);
         op(1'b1, 3'd0, m_stage_u, 1'b0);
         op(1'b1, 3'd1, m_stage_l, 1'b0);
         m_stage_u &= ~32'h7; m_stage_l &= ~32'h7;
         rd(3'd0, v); chk("R2 upper readback", v, m_stage_u);
         rd(3'd1, v); chk("R2 lower readback", v, m_stage_l);
         chk("R3 upper held", cur_upper, m_cur_u);
         chk("R3 lower held", cur_lower, m_cur_l);
         op(1'b0, 3'd0, 0, 1'b1);
         m_cur_u = m_stage_u; m_cur_l = m_stage_l;
         chk("R4 upper swapped", cur_upper, m_cur_u);
         chk("R4 lower swapped", cur_lower, m_cur_l);
         chk("R2 cur low bits", cur_upper & 32'h7, 0);
      end

      // R6 / R7 flag and interrupt
      rd(3'd2, v); chk("R6 flag set", v, 1);
      chk("R7 irq masked", {31'b0, irq}, 0);
      op(1'b1, 3'd3, 32'hFFFF_FFFF, 1'b0);
      rd(3'd3, v); chk("R10 mask read", v, 1);
      chk("R7 irq unmasked", {31'b0, irq}, 1);
      op(1'b1, 3'd2, 32'hFFFF_FFFE, 1'b0);
      rd(3'd2, v); chk("R6 write0 no effect", v, 1);
      op(1'b1, 3'd2, 32'h1, 1'b0);
      rd(3'd2, v); chk("R6 clear", v, 0);
      chk("R7 irq after clear", {31'b0, irq}, 0);
      op(1'b1, 3'd2, 32'h1, 1'b1);
      rd(3'd2, v); chk("R6 set beats clear", v, 1);
      chk("R7 irq set", {31'b0, irq}, 1);
      op(1'b1, 3'd3, 32'h0, 1'b0);
      chk("R7 irq remasked", {31'b0, irq}, 0);

      // R5 write with vsync in same cycle
      op(1'b1, 3'd0, 32'hA000_0008, 1'b0);
      op(1'b1, 3'd0, 32'hB000_0010, 1'b1);
      chk("R5 old value swapped", cur_upper, 32'hA000_0008);
      rd(3'd0, v); chk("R5 new value staged", v, 32'hB000_0010);
      op(1'b0, 3'd0, 0, 1'b1);
      chk("R5 new value next vsync", cur_upper, 32'hB000_0010);
      m_cur_u = 32'hB000_0010;

      // R9 single-panel mode
      dual_panel = 1'b0;
      op(1'b1, 3'd1, 32'h4444_4440, 1'b0);
      op(1'b1, 3'd0, 32'h5555_5550, 1'b1);
      op(1'b0, 3'd0, 0, 1'b1);
      chk("R9 lower held", cur_lower, m_cur_l);
      chk("R9 upper still swaps", cur_upper, 32'h5555_5550);
      dual_panel = 1'b1;
      op(1'b0, 3'd0, 0, 1'b1);
      chk("R9 lower swaps in dual", cur_lower, 32'h4444_4440);

      // R8 disabled tracking, vsync ignored
      ctrl_en = 1'b0;
      op(1'b1, 3'd2, 32'h1, 1'b0);
      op(1'b1, 3'd0, 32'h7777_777F, 1'b0);
      @(negedge clk);
      chk("R8 upper tracks", cur_upper, 32'h7777_7778);
      op(1'b1, 3'd1, 32'h0000_1239, 1'b0);
      @(negedge clk);
      chk("R8 lower tracks", cur_lower, 32'h0000_1238);
      op(1'b0, 3'd0, 0, 1'b1);
      rd(3'd2, v); chk("R8 vsync ignored", v, 0);

      // R10 unused offsets
      for (int a = 4; a < 8; a++) begin rd(3'(a), v); chk("R10 unused offset", v, 0); end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule